// File: doc/BRIEF.md
# Serial Clock Prescaler Search Unit

This block picks the setting of a two-stage serial clock prescaler. Given a core clock frequency and a wanted serial bit rate, both as 32-bit integers in hertz, it tries prescaler pairs one at a time. The first stage is a linear divider `m` from 1 to 15. The second stage is a power-of-two divider `e` from 0 to 7. The total divisor is `m * 2^e`. The unit keeps the pair whose integer rate `core / (m * 2^e)` comes closest to the wanted rate without going above it. It returns that pair packed into the byte layout used by the serial controller's configuration register.

A one-cycle `start` pulse captures both frequencies. The unit then walks the candidates. `m` is the outer loop and `e` is the inner loop, both counting upward. Each quotient comes from a shared iterative divider that produces one quotient bit per cycle. The search stops early when a rate matches exactly. When it finishes, `done` pulses for one cycle. `cfg` and `err` then hold their values until the next accepted start.

The control is a five-state machine:
- **IDLE** waits for `start`. With a legal request it goes to LAUNCH. When the core clock equals the wanted rate it goes straight to FINISH with the error flag set.
- **LAUNCH** starts the divider on the current candidate.
- **WAIT** stays until the divider reports its quotient.
- **EVAL** judges the quotient. It goes to FINISH on an exact hit or after the last candidate. Otherwise it advances to the next candidate and returns to LAUNCH.
- **FINISH** raises `done` and returns to IDLE.

Top module: `baud_prescale_search`

## Requirements
- R1: After reset `busy` and `done` are low.
- R2: An accepted `start` makes `busy` high from the next cycle until the result cycle. `done` is high for exactly one cycle per accepted request.
- R3: For a legal request where no exact match exists, all 120 candidates are tried. The result is the candidate with the smallest shortfall (wanted minus quotient). A full search takes more than 3000 cycles.
- R4: A candidate whose quotient exceeds the wanted rate is never chosen. When `err` is low, `core / (m * 2^e)` rebuilt from `cfg` is at most the wanted rate.
- R5: A quotient equal to the wanted rate ends the search at once with that candidate. When this happens at the second candidate, `done` comes within 100 cycles of the start.
- R6: When several candidates share the smallest shortfall, the first one in scan order wins.
- R7: If every quotient is above the wanted rate, `err` is 1 and `cfg` is 0.
- R8: `cfg[3:0]` holds `m`, `cfg[4]` holds bit 0 of `e`, `cfg[7:6]` hold bits 2:1 of `e`, and `cfg[5]` is 0.
- R9: A request with core clock equal to the wanted rate sets `err` and gives `cfg` 0. `done` appears in the cycle right after `start` is accepted, without any search.
- R10: `cfg` and `err` keep their values after `done` until the next accepted start.
- R11: A `start` that arrives while `busy` is high is ignored and does not change the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; captures both frequencies when idle |
| core_hz | input | 32 | Core clock frequency |
| target_hz | input | 32 | Wanted serial rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | No qualifying candidate, or illegal request |
| cfg | output | 8 | Packed prescaler field |

## Verification
The bench builds the unit with its default values: a 32-bit datapath, `m` up to 15 and `e` up to 7. This gives the full 120-candidate grid and real-sized frequencies such as 250 MHz. With these values the bench can reach:
- an exact hit deep in the scan and an exact hit on the second candidate;
- the largest power-of-two stage, which sets both split bit fields;
- a tie between `1*2^1` and `2*2^0`;
- wanted rates below the smallest reachable rate, and wanted rates above the core clock.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_WAIT,
        S_EVAL,
        S_FINISH
    } srch_state_t;

    localparam int LIN_W = 4;   // width of the linear stage field
    localparam int EXP_W = 3;   // width of the power-of-two stage field

endpackage

// File: rtl/baud_div.sv
module baud_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, num_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, fin_q;
    logic [W:0]    diff;

    // shift the next numerator bit into the remainder, then try to subtract
    assign diff = {rem_q, quo_q[W-1]} - {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            num_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= num;
                num_q <= num;
                den_q <= den;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!diff[W]) begin
                    rem_q <= diff[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[W-2:0], quo_q[W-1]};
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin = fin_q;
    assign quo = quo_q;

    // R3: a finished quotient q satisfies q*d <= n < (q+1)*d
    p_quot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (({{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q}) <= {{W{1'b0}}, num_q}) &&
                (({{W{1'b0}}, num_q} - ({{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q})) < {{W{1'b0}}, den_q}));

    p_fin_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/baud_cfg_pack.sv
module baud_cfg_pack
    import baud_pkg::*;
(
    input  logic [LIN_W-1:0] lin,
    input  logic [EXP_W-1:0] expo,
    output logic [7:0]       cfg
);
    // R8: split field, bit 5 is left clear for a neighbouring setting
    always_comb begin
        cfg      = '0;
        cfg[3:0] = lin;
        cfg[4]   = expo[0];
        cfg[7:6] = expo[2:1];
    end
endmodule

// File: rtl/baud_prescale_search.sv
module baud_prescale_search
    import baud_pkg::*;
#(
    parameter int W        = 32,
    parameter int LIN_MAX  = 15,
    parameter int EXP_MAX  = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] core_hz,
    input  logic [W-1:0] target_hz,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [7:0]   cfg
);
    localparam logic [LIN_W-1:0] LIN_LAST = LIN_W'(LIN_MAX);
    localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(EXP_MAX);

    srch_state_t state_q, state_d;

    logic [W-1:0]     core_q, tgt_q, best_gap_q;
    logic [LIN_W-1:0] lin_q, best_lin_q;
    logic [EXP_W-1:0] exp_q, best_exp_q;
    logic             bad_q;

    logic             div_go, div_fin;
    logic [W-1:0]     div_quo, div_den, gap;
    logic             over, hit, last;

    assign div_den = W'(lin_q) << exp_q;
    assign div_go  = (state_q == S_LAUNCH);
    assign over    = div_quo > tgt_q;
    assign hit     = div_quo == tgt_q;
    assign gap     = tgt_q - div_quo;
    assign last    = (lin_q == LIN_LAST) && (exp_q == EXP_LAST);

    baud_div #(.W(W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (core_q),
        .den  (div_den),
        .fin  (div_fin),
        .quo  (div_quo)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = (core_hz == target_hz) ? S_FINISH : S_LAUNCH;
            S_LAUNCH: state_d = S_WAIT;
            S_WAIT:   if (div_fin) state_d = S_EVAL;
            S_EVAL:   state_d = ((!over && hit) || last) ? S_FINISH : S_LAUNCH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q     <= '0;
            tgt_q      <= '0;
            best_gap_q <= '1;
            lin_q      <= '0;
            exp_q      <= '0;
            best_lin_q <= '0;
            best_exp_q <= '0;
            bad_q      <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                core_q     <= core_hz;
                tgt_q      <= target_hz;
                bad_q      <= (core_hz == target_hz);
                lin_q      <= LIN_W'(1);
                exp_q      <= '0;
                best_lin_q <= '0;
                best_exp_q <= '0;
                best_gap_q <= '1;
            end
            if (state_q == S_EVAL) begin
                if (!over) begin
                    if (hit || (gap < best_gap_q)) begin
                        best_lin_q <= lin_q;
                        best_exp_q <= exp_q;
                        best_gap_q <= gap;
                    end
                end
                if (exp_q == EXP_LAST) begin
                    exp_q <= '0;
                    lin_q <= lin_q + 1'b1;
                end else begin
                    exp_q <= exp_q + 1'b1;
                end
            end
        end
    end

    baud_cfg_pack u_pack (
        .lin (best_lin_q),
        .expo(best_exp_q),
        .cfg (cfg)
    );

    // outputs
    always_comb begin
        busy = (state_q == S_LAUNCH) || (state_q == S_WAIT) || (state_q == S_EVAL);
        done = (state_q == S_FINISH);
        err  = bad_q || (best_lin_q == '0);
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && core_hz == target_hz) |=> (done && err && cfg == 8'h00));

    p_hit_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL && div_quo == tgt_q) |=> done);

    p_pack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (cfg[3:0] != 4'd0) && !cfg[5]);

    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tgt_q) && $stable(core_q));

endmodule

// File: tb/tb_baud_prescale_search.sv
module tb_baud_prescale_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] core_hz = '0;
    logic [31:0] target_hz = '0;
    logic        busy, done, err;
    logic [7:0]  cfg;

    always #10 clk = ~clk;   // 50 MHz

    baud_prescale_search dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .core_hz(core_hz), .target_hz(target_hz),
        .busy(busy), .done(done), .err(err), .cfg(cfg)
    );

    typedef struct {
        logic [7:0]  cfg;
        logic        err;
        int          min_lat;
        int          max_lat;
        logic [31:0] c;
        logic [31:0] t;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // independent model of the search
    function automatic logic [8:0] model(input logic [31:0] c, input logic [31:0] t);
        logic [31:0] best_gap = 32'hFFFF_FFFF;
        int          bm = 0, be = 0;
        bit          stop = 0;
        if (c == t) return 9'h100;
        for (int m = 1; m <= 15 && !stop; m++) begin
            for (int e = 0; e <= 7 && !stop; e++) begin
                logic [31:0] q;
                q = c / (32'(m) << e);
                if (q <= t) begin
                    if (q == t) begin
                        bm = m; be = e; stop = 1;
                    end else if ((t - q) < best_gap) begin
                        best_gap = t - q; bm = m; be = e;
                    end
                end
            end
        end
        if (bm == 0) return 9'h100;
        return {1'b0, 2'(be >> 1), 1'b0, 1'(be), 4'(bm)};
    endfunction

    // driver
    task automatic send(input logic [31:0] c, input logic [31:0] t, input string tag,
                        input int min_lat, input int max_lat, input bit poke);
        exp_t x;
        logic [8:0] r;
        r = model(c, t);
        x.err = r[8]; x.cfg = r[7:0]; x.min_lat = min_lat; x.max_lat = max_lat;
        x.c = c; x.t = t; x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        core_hz = c; target_hz = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            core_hz = 32'd999; target_hz = 32'd7; start = 1'b1;   // R11: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        wait (sb.size() == 0);
        repeat (6) @(negedge clk);
        chk(cfg == x.cfg && err == x.err, {"R10 hold ", tag}, {err, cfg}, {x.err, x.cfg});
    endtask

    // monitor
    int lat = 0;
    bit prev_busy = 0, prev_done = 0, gap_seen = 0;
    initial begin
        forever begin
            @(posedge clk); #5;
            if (start && !prev_busy && !prev_done) begin
                lat = 0; gap_seen = 0;
            end else begin
                lat++;
            end
            if (sb.size() != 0 && lat > 0 && !busy && !done) gap_seen = 1;
            if (prev_done && done) chk(0, "R2 done width", 1, 0);
            if (done) begin
                if (sb.size() == 0) begin
                    chk(0, "R2 unexpected done", 1, 0);
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    chk(cfg == x.cfg, {"R3 cfg ", x.tag}, cfg, x.cfg);
                    chk(err == x.err, {"R7 err ", x.tag}, err, x.err);
                    chk(lat >= x.min_lat && lat <= x.max_lat, {"R5 latency ", x.tag}, lat, x.max_lat);
                    chk(!gap_seen, {"R2 busy ", x.tag}, 0, 1);
                    if (!err) begin
                        int m, e;
                        m = int'(cfg[3:0]);
                        e = int'({cfg[7:6], cfg[4]});
                        chk(cfg[5] == 1'b0 && m != 0, {"R8 field ", x.tag}, cfg, x.cfg);
                        chk((x.c / (32'(m) << e)) <= x.t, {"R4 not above ", x.tag},
                            x.c / (32'(m) << e), x.t);
                    end
                end
            end
            prev_busy = busy;
            prev_done = done;
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 after release", {busy, done}, 0);

        // R5: exact hit on the second candidate (1*2^1), early stop
        send(32'd1000, 32'd500, "R5 early exact", 1, 100, 0);
        chk(cfg == 8'h11, "R8 pack 1,1", cfg, 8'h11);
        // exact hit deeper in the scan (m=5)
        send(32'd250_000_000, 32'd50_000_000, "R5 deep exact", 100, 3000, 0);
        chk(cfg == 8'h05, "R5 deep cfg", cfg, 8'h05);
        // R8: largest power-of-two stage sets both split fields
        send(32'd1_000_000, 32'd7812, "R8 e=7", 1, 400, 0);
        chk(cfg == 8'hD1, "R8 pack 1,7", cfg, 8'hD1);
        // R3: no exact match, full scan
        send(32'd250_000_000, 32'd20_971_520, "R3 full scan", 3000, 5000, 0);
        // R6: tie between 1*2^1 and 2*2^0, earlier one wins
        send(32'd1001, 32'd501, "R6 tie", 3000, 5000, 0);
        chk(cfg == 8'h11, "R6 first found", cfg, 8'h11);
        // R4: quotients above the target are skipped
        send(32'd1000, 32'd499, "R4 skip above", 3000, 5000, 0);
        // R7: everything above the target
        send(32'd100_000, 32'd10, "R7 none fit", 3000, 5000, 0);
        chk(cfg == 8'h00 && err, "R7 zero cfg", {err, cfg}, 9'h100);
        // R9: illegal request
        send(32'd12345, 32'd12345, "R9 illegal", 0, 0, 0);
        chk(cfg == 8'h00 && err, "R9 flag", {err, cfg}, 9'h100);
        // target above the core clock: the undivided rate is nearest
        send(32'd100, 32'd1000, "R3 above core", 3000, 5000, 0);
        chk(cfg == 8'h01, "R3 undivided", cfg, 8'h01);
        // R11: start while busy is ignored
        send(32'd250_000_000, 32'd9_000_000, "R11 poke", 3000, 5000, 1);

        seed = 32'h1234_5678;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] c, t;
            seed = seed * 32'd1664525 + 32'd1013904223;
            c = 32'd1_000_000 + (seed >> 4);
            seed = seed * 32'd1664525 + 32'd1013904223;
            t = (c >> (seed[31:29] + 1)) + {28'd0, seed[3:0]};
            send(c, t, "R3 mixed", 0, 5000, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule